// File: doc/BRIEF.md
# Two-Slot Shared RAM with Page Write Lock

This block is a single RAM that serves two masters: an 8-bit processor and a video scanout engine. The RAM clock runs at twice the processor rate. Each processor cycle is two RAM cycles, and each master owns one of them. The even cycle belongs to the processor and the odd cycle to the video reader. The `cpuSlot` output marks the processor's cycle. Because the split is fixed, there is no request, grant or wait: each master always gets its access on time.

The processor side follows a simple system bus. It presents an address, write data and one write-enable. Read data is produced on every processor cycle and selected by address: RAM data inside the window, the lock register at its own control address, and zero elsewhere. The RAM window is `NUM_PAGES` pages of `2**PAGE_BITS` bytes starting at `WIN_BASE`. With `PAGE_BITS=12`, five pages and a base of 0x8000, the window is a 20 kB area at 0x8000–0xCFFF with a 4 kB lock grain.

Each page has one lock bit. Boot code can load an image, such as an interpreter at 0xA000–0xBFFF, and then lock it so that it behaves as ROM. The video port only reads, and its data is held for a whole processor cycle. The default parameters shrink the pages to 256 bytes so the memory stays small.

Top module: `slotram_top`

## Requirements
- R1: After reset, `cpuRdata` and `vidRdata` are zero, the lock register is zero (no page locked), and `cpuSlot` is high in the first RAM cycle after reset is released.
- R2: `cpuSlot` toggles on every RAM clock edge while out of reset. A high value marks the processor slot and a low value marks the video slot.
- R3: A processor write in its slot to a window address on an unlocked page stores `cpuWdata` at offset `cpuAddr - WIN_BASE`.
- R4: `cpuRdata` is loaded at the rising edge that ends the processor slot and holds through the video slot. On a write, the value returned is the one held before that write.
- R5: The lock register sits at `CTRL_ADDR`. A write there loads bits [NUM_PAGES-1:0] of `cpuWdata`. A read returns the register in those bits, with all higher bits zero.
- R6: Bit i of the lock register locks page i, the window offsets i·2^PAGE_BITS through (i+1)·2^PAGE_BITS−1. A processor write to a locked page is dropped. Reads of that page, from either master, still return the stored data.
- R7: A processor access outside the window and not at `CTRL_ADDR` returns zero and changes neither the RAM nor the lock register. This includes the first byte past the window's end.
- R8: `vidRdata` is loaded at the rising edge that ends the video slot with the byte at window offset `vidAddr`, or zero when that offset is beyond the window. A write in the processor slot just before is already visible.
- R9: `vidRdata` does not change at the edge that ends a processor slot.
- R10: Locking one page has no effect on writes to the pages next to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RAM clock, twice the processor rate |
| rstN | input | 1 | Synchronous reset, active low |
| cpuSlot | output | 1 | High during the processor's RAM cycle |
| cpuAddr | input | ADDR_W | Processor address |
| cpuWe | input | 1 | Processor write enable |
| cpuWdata | input | DATA_W | Processor write data |
| cpuRdata | output | DATA_W | Address-selected processor read data |
| vidAddr | input | OFF_W | Video read offset within the window |
| vidRdata | output | DATA_W | Video read data, held one processor cycle |

## Verification
A wrong slot phase shows up within one processor cycle. Processor read-back and video data then land on the wrong edge, and fresh writes would be missing from the next video read. A stale or corrupted lock register shows up at the next write into the page concerned. Either the byte changes when it should not, or it stays when it should change, and the following read of that offset exposes the difference. Address-decode errors show up at once as non-zero data outside the window, or as lock-register contents that differ from the last control write.

// File: rtl/slotram_pkg.sv
package slotram_pkg;

  // Strobes issued by the control for one RAM cycle
  typedef struct packed {
    logic memWr;     // commit processor write to RAM
    logic cpuLatch;  // capture processor read data
    logic vidLatch;  // capture video read data
  } slotStrobe_t;

  // Source of processor read data
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_RAM  = 2'd1,
    RD_LOCK = 2'd2
  } rdSrc_t;

endpackage

// File: rtl/slotram_ctrl.sv
module slotram_ctrl
  import slotram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 8,
  parameter int NUM_PAGES = 5,
  parameter int WIN_BASE  = 'h8000,
  parameter int CTRL_ADDR = 'hE000,
  parameter int PG_W      = 3,
  parameter int OFF_W     = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 cpuWe,
  input  logic [NUM_PAGES-1:0] lockIn,
  output logic                 cpuSlot,
  output slotStrobe_t          strb,
  output rdSrc_t               rdSrc,
  output logic [OFF_W-1:0]     ramOff,
  output logic [NUM_PAGES-1:0] lockQ
);

  localparam int DEPTH = NUM_PAGES << PAGE_BITS;
  localparam logic [ADDR_W:0]   WIN_LO  = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0]   WIN_HI  = (ADDR_W+1)'(WIN_BASE + DEPTH);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);

  logic           oddPhase;
  logic           inWin;
  logic           isCtrl;
  logic [PG_W-1:0] pageIdx;
  logic           pageLocked;

  // Slot phase: low = processor slot, high = video slot
  always_ff @(posedge clk) begin
    if (!rstN) oddPhase <= 1'b0;
    else       oddPhase <= ~oddPhase;
  end

  assign cpuSlot = ~oddPhase;

  // Address decode
  always_comb begin
    inWin  = ({1'b0, cpuAddr} >= WIN_LO) && ({1'b0, cpuAddr} < WIN_HI);
    isCtrl = (cpuAddr == CTRL_A);
    ramOff = OFF_W'(cpuAddr - BASE_A);
    pageIdx = ramOff[OFF_W-1 -: PG_W];
    pageLocked = inWin && lockQ[pageIdx];
  end

  always_comb begin
    if (inWin)       rdSrc = RD_RAM;
    else if (isCtrl) rdSrc = RD_LOCK;
    else             rdSrc = RD_NONE;
  end

  always_comb begin
    strb.cpuLatch = ~oddPhase;
    strb.vidLatch = oddPhase;
    strb.memWr    = ~oddPhase & cpuWe & inWin & ~pageLocked;
  end

  // Page lock register
  always_ff @(posedge clk) begin
    if (!rstN) lockQ <= '0;
    else if (~oddPhase && cpuWe && isCtrl) lockQ <= lockIn;
  end

endmodule

// File: rtl/slotram_dp.sv
module slotram_dp
  import slotram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 5,
  parameter int OFF_W     = 11,
  parameter int DEPTH     = 1280
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  slotStrobe_t          strb,
  input  rdSrc_t               rdSrc,
  input  logic [OFF_W-1:0]     ramOff,
  input  logic [DATA_W-1:0]    cpuWdata,
  input  logic [NUM_PAGES-1:0] lockQ,
  input  logic [OFF_W-1:0]     vidAddr,
  output logic [DATA_W-1:0]    cpuRdata,
  output logic [DATA_W-1:0]    vidRdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              vidHit;

  assign vidHit = (32'(vidAddr) < DEPTH);

  always_ff @(posedge clk) begin
    if (strb.memWr) mem[ramOff] <= cpuWdata;
  end

  // Processor read: sampled at the end of its slot, old data on a write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdata <= '0;
    end else if (strb.cpuLatch) begin
      case (rdSrc)
        RD_RAM:  cpuRdata <= mem[ramOff];
        RD_LOCK: cpuRdata <= DATA_W'(lockQ);
        default: cpuRdata <= '0;
      endcase
    end
  end

  // Video read: sampled at the end of the odd slot
  always_ff @(posedge clk) begin
    if (!rstN)              vidRdata <= '0;
    else if (strb.vidLatch) vidRdata <= vidHit ? mem[vidAddr] : '0;
  end

endmodule

// File: rtl/slotram_top.sv
module slotram_top
  import slotram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 8,
  parameter int NUM_PAGES = 5,
  parameter int WIN_BASE  = 'h8000,
  parameter int CTRL_ADDR = 'hE000,
  localparam int PG_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int OFF_W    = PAGE_BITS + PG_W,
  localparam int DEPTH    = NUM_PAGES << PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              cpuSlot,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic [OFF_W-1:0]  vidAddr,
  output logic [DATA_W-1:0] vidRdata
);

  slotStrobe_t          strb;
  rdSrc_t               rdSrc;
  logic [OFF_W-1:0]     ramOff;
  logic [NUM_PAGES-1:0] lockQ;

  slotram_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .NUM_PAGES(NUM_PAGES),
    .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR), .PG_W(PG_W), .OFF_W(OFF_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .lockIn(cpuWdata[NUM_PAGES-1:0]), .cpuSlot(cpuSlot), .strb(strb),
    .rdSrc(rdSrc), .ramOff(ramOff), .lockQ(lockQ)
  );

  slotram_dp #(
    .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .OFF_W(OFF_W), .DEPTH(DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSrc(rdSrc), .ramOff(ramOff),
    .cpuWdata(cpuWdata), .lockQ(lockQ), .vidAddr(vidAddr),
    .cpuRdata(cpuRdata), .vidRdata(vidRdata)
  );

endmodule

// File: rtl/slotram_chk.sv
module slotram_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 8,
  parameter int NUM_PAGES = 5,
  parameter int WIN_BASE  = 'h8000,
  parameter int CTRL_ADDR = 'hE000
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuSlot,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuRdata,
  input logic [DATA_W-1:0] vidRdata
);

  localparam int SPAN = NUM_PAGES << PAGE_BITS;

  logic outside;
  assign outside = ((32'(cpuAddr) < WIN_BASE) || (32'(cpuAddr) >= WIN_BASE + SPAN))
                   && (32'(cpuAddr) != CTRL_ADDR);

  AST_SLOT_TO_VIDEO: assert property (@(posedge clk) disable iff (!rstN)
    cpuSlot |=> !cpuSlot);  // R2
  AST_VIDEO_TO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    !cpuSlot |=> cpuSlot);  // R2
  AST_CPU_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cpuSlot |=> $stable(cpuRdata));  // R4
  AST_VID_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cpuSlot |=> $stable(vidRdata));  // R9
  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSlot && outside) |=> (cpuRdata == '0));  // R7
  AST_LOCK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSlot && (32'(cpuAddr) == CTRL_ADDR)) |=> ((cpuRdata >> NUM_PAGES) == '0));  // R5

endmodule

bind slotram_top slotram_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
  .NUM_PAGES(NUM_PAGES), .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .cpuSlot(cpuSlot), .cpuAddr(cpuAddr),
  .cpuRdata(cpuRdata), .vidRdata(vidRdata)
);

// File: tb/slotram_top_tb_top.sv
`timescale 1ns/1ps
module slotram_top_tb_top;

  localparam int BASE  = 'h8000;
  localparam int CTRL  = 'hE000;
  localparam int PGB   = 8;
  localparam int NPG   = 5;
  localparam int DEPTH = NPG << PGB;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSlot;
  logic [15:0] cpuAddr = '0;
  logic        cpuWe = 1'b0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic [10:0] vidAddr = '0;
  logic [7:0]  vidRdata;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  logic [7:0]     model [DEPTH];
  logic [NPG-1:0] lockM = '0;

  always #5 clk = ~clk;

  slotram_top dut_i (
    .clk(clk), .rstN(rstN), .cpuSlot(cpuSlot), .cpuAddr(cpuAddr),
    .cpuWe(cpuWe), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .vidAddr(vidAddr), .vidRdata(vidRdata)
  );

  function automatic bit inWin(input logic [15:0] a);
    return (int'(a) >= BASE) && (int'(a) < BASE + DEPTH);
  endfunction

  function automatic logic [7:0] expCpu(input logic [15:0] a);
    if (inWin(a))          return model[int'(a) - BASE];
    if (int'(a) == CTRL)   return 8'(lockM);
    return 8'h00;
  endfunction

  function automatic logic [7:0] expVid(input logic [10:0] va);
    return (int'(va) < DEPTH) ? model[int'(va)] : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One processor cycle: entered at a negedge with cpuSlot high, leaves likewise
  task automatic cpuOp(input logic [15:0] a, input logic we, input logic [7:0] d,
                       input logic [10:0] va, input string req);
    logic [7:0] eC;
    logic [7:0] eV;
    check(cpuSlot == 1'b1, "R2", cpuSlot, 1);
    eC = expCpu(a);
    cpuAddr = a; cpuWe = we; cpuWdata = d; vidAddr = va;
    @(posedge clk); #1;
    check(cpuRdata == eC, req, cpuRdata, eC);
    if (we) begin
      if (inWin(a)) begin
        if (!lockM[(int'(a) - BASE) >> PGB]) model[int'(a) - BASE] = d;
      end else if (int'(a) == CTRL) begin
        lockM = d[NPG-1:0];
      end
    end
    eV = expVid(va);
    @(negedge clk);
    check(cpuSlot == 1'b0, "R2", cpuSlot, 0);
    cpuWe = 1'b0;
    @(posedge clk); #1;
    check(vidRdata == eV, "R8", vidRdata, eV);
    @(negedge clk);
    check(cpuRdata == eC, "R4", cpuRdata, eC);
  endtask

  initial begin
    void'($urandom(32'h5107_2A11));
    repeat (3) @(negedge clk);
    // R1: reset values
    check(cpuRdata == 8'h00, "R1", cpuRdata, 0);
    check(vidRdata == 8'h00, "R1", vidRdata, 0);
    rstN = 1'b1;
    check(cpuSlot == 1'b1, "R1", cpuSlot, 1);
    cpuOp(16'(CTRL), 1'b0, 8'h00, 11'd0, "R1");   // lock register reads zero

    // R3: fill every window byte, video follows behind
    for (int i = 0; i < DEPTH; i++)
      cpuOp(16'(BASE + i), 1'b1, 8'($urandom), 11'(i), "R3");
    for (int i = 0; i < 40; i++)
      cpuOp(16'(BASE + int'($urandom % DEPTH)), 1'b0, 8'h00, 11'($urandom % DEPTH), "R3");

    // R4: write returns pre-write data
    cpuOp(16'(BASE + 16), 1'b1, 8'hA5, 11'd16, "R4");
    cpuOp(16'(BASE + 16), 1'b1, 8'h5A, 11'd16, "R4");
    cpuOp(16'(BASE + 16), 1'b0, 8'h00, 11'd16, "R4");

    // R5: lock register keeps only the low page bits
    cpuOp(16'(CTRL), 1'b1, 8'hFF, 11'd0, "R5");
    cpuOp(16'(CTRL), 1'b0, 8'h00, 11'd0, "R5");
    cpuOp(16'(CTRL), 1'b1, 8'h04, 11'd0, "R5");
    cpuOp(16'(CTRL), 1'b0, 8'h00, 11'd0, "R5");

    // R6: page 2 locked, write dropped, both masters still read it
    cpuOp(16'(BASE + 2*256 + 7), 1'b1, 8'hC3, 11'(2*256 + 7), "R6");
    cpuOp(16'(BASE + 2*256 + 7), 1'b0, 8'h00, 11'(2*256 + 7), "R6");
    cpuOp(16'(BASE + 2*256), 1'b1, 8'h3C, 11'(2*256), "R6");
    cpuOp(16'(BASE + 3*256 - 1), 1'b1, 8'h3C, 11'(3*256 - 1), "R6");

    // R10: neighbours of the locked page stay writable
    cpuOp(16'(BASE + 2*256 - 1), 1'b1, 8'h11, 11'(2*256 - 1), "R10");
    cpuOp(16'(BASE + 3*256), 1'b1, 8'h22, 11'(3*256), "R10");
    cpuOp(16'(BASE + 2*256 - 1), 1'b0, 8'h00, 11'(2*256 - 1), "R10");
    cpuOp(16'(BASE + 3*256), 1'b0, 8'h00, 11'(3*256), "R10");

    // R7: outside writes change nothing, reads return zero
    cpuOp(16'(BASE + DEPTH), 1'b1, 8'h77, 11'd0, "R7");
    cpuOp(16'(BASE - 1), 1'b1, 8'h77, 11'(DEPTH - 1), "R7");
    cpuOp(16'(BASE + DEPTH), 1'b0, 8'h00, 11'(DEPTH - 1), "R7");
    cpuOp(16'(CTRL + 1), 1'b1, 8'h1F, 11'd0, "R7");
    cpuOp(16'(CTRL), 1'b0, 8'h00, 11'd0, "R7");
    cpuOp(16'(BASE), 1'b0, 8'h00, 11'd0, "R7");
    cpuOp(16'(BASE + DEPTH - 1), 1'b1, 8'h99, 11'(DEPTH - 1), "R3");

    // R8: video offset past window returns zero
    cpuOp(16'(BASE), 1'b0, 8'h00, 11'(DEPTH), "R8");
    cpuOp(16'(BASE), 1'b0, 8'h00, 11'h7FF, "R8");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [15:0] a;
      sel = int'($urandom % 20);
      if (sel < 14)       a = 16'(BASE + int'($urandom % DEPTH));
      else if (sel < 16)  a = 16'(CTRL);
      else if (sel < 18)  a = 16'(BASE + DEPTH + int'($urandom % 256));
      else                a = 16'($urandom);
      cpuOp(a, 1'($urandom), 8'($urandom), 11'($urandom), "R6");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule